// File: doc/BRIEF.md
# Capture-Compare Status Flag Unit

This block is one timer channel: a free-running up-counter and a small set of general registers. Each general register works either as a compare register or as a capture register. Each register owns a sticky status flag. In compare mode the flag is raised when the counter steps onto the register's value. In capture mode it is raised when a synchronised edge on that register's capture pin copies the counter into the register.

Software clears a flag with a two-step handshake. It must first read the status word with the flag at 1, and then write a 0 to that flag bit. A transfer engine that services a flag's interrupt request can also clear the flag, unless it raises its no-clear qualifier. Each flag drives its own interrupt request through an enable bit.

A build parameter removes the general registers and flags entirely, for channels that do not carry them. The counter stays in place.

Host accesses use a simple strobe bus with combinational read data. Address map: 0 counter, 1 control, 2 status, 3 + i general register i. The control word holds three groups of bits. For register i, bit i is the mode (1 = capture), bit NREG+i is the capture edge (1 = falling) and bit 2·NREG+i is the interrupt enable. Status bit i is flag i.

Top module: `ccu_chan`

## Requirements
- R1: The counter (address 0) rises by one at each clock edge where `cnt_tick` is 1. A host write to address 0 loads it, and the write takes priority over a tick in the same cycle.
- R2: With control bit i at 0 (compare mode), a host write to address 3+i loads register i. Flag i sets at the same edge at which a tick moves the counter onto register i's value.
- R3: With control bit i at 1 (capture mode), a selected edge on `cap_in[i]` copies the counter into register i and sets flag i. Both happen on the third clock edge after the pin changes, which accounts for two synchroniser stages and an edge detector. Host writes to register i are ignored in this mode.
- R4: Control bit NREG+i selects the capture edge for register i: 0 is rising, 1 is falling. The other edge does nothing.
- R5: A write to address 2 with bit i at 0 clears flag i only if a read of address 2 returned bit i as 1 since the flag was last cleared. That arming survives further set events on the same flag.
- R6: Writing 1 to a status bit leaves the flag unchanged. Writing 0 leaves it unchanged if no read has armed it.
- R7: A pulse on `xfer_ack[i]` clears flag i when `xfer_noclr` is 0, and has no effect when `xfer_noclr` is 1.
- R8: When a set event and a clear request for the same flag fall in one cycle, the flag ends up set.
- R9: `irq[i]` equals flag i ANDed with control bit 2·NREG+i. It rises in the same cycle as the flag and stays high until the flag clears.
- R10: With `HAS_REGS` = 0, status, control and the general registers always read 0 and ignore writes, and `irq` stays 0.
- R11: After reset the counter, control word and flags are 0, and the general registers hold all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count enable for this cycle |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (arms flags read as 1) |
| host_wdata | input | CNT_W | Write data |
| host_rdata | output | CNT_W | Combinational read data |
| cap_in | input | NREG | Asynchronous capture pins |
| xfer_ack | input | NREG | Transfer engine service pulse per flag |
| xfer_noclr | input | 1 | Suppresses the clear on a service pulse |
| irq | output | NREG | Interrupt request per flag |

## Verification
Three latencies matter. A compare-match flag and the counter step appear together, one edge after a tick. A host or transfer-engine clear takes effect one edge after the strobe. A capture lands three edges after the pin change. The bench drives every input at the falling clock edge and samples outputs at the next falling edge. For capture it counts edges explicitly, so it confirms the flag is still low after two edges and set after the third. Read data is sampled just after the read strobe is applied, before the edge at which the read arms the flag.

// File: rtl/ccu_pkg.sv
// Shared address constants for the capture-compare channel.
// Assumes general register i sits at GR_BASE + i.
package ccu_pkg;
    localparam int A_CNT   = 0;
    localparam int A_CTRL  = 1;
    localparam int A_STAT  = 2;
    localparam int GR_BASE = 3;
endpackage

// File: rtl/ccu_edge_sync.sv
// Brings an asynchronous capture pin into the clock domain through
// STAGES flops and produces a one-cycle pulse on the chosen edge.
// Assumes the pin is low while reset is held.
module ccu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Select the rising or the falling transition.
    always_comb begin
        if (fall_sel) edge_o = prev_q & ~sync_q[STAGES-1];
        else          edge_o = ~prev_q & sync_q[STAGES-1];
    end
endmodule

// File: rtl/ccu_gr.sv
// One general register. In compare mode the host loads it and a match
// is reported when the counter advances onto its value. In capture mode
// a capture pulse loads the current count and host writes are ignored.
module ccu_gr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         cap_evt,
    input  logic [W-1:0] cnt_now,
    input  logic [W-1:0] cnt_next,
    input  logic         cnt_adv,
    input  logic         host_we,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] gr,
    output logic         set_evt
);
    // Register contents: capture load or host load depending on mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gr <= '1;
        else if (cap_mode && cap_evt)   gr <= cnt_now;
        else if (!cap_mode && host_we)  gr <= host_wdata;
    end

    // Flag set source for this register.
    always_comb begin
        if (cap_mode) set_evt = cap_evt;
        else          set_evt = cnt_adv && (cnt_next == gr);
    end

    assert_capture_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode && cap_evt |=> gr == $past(cnt_now));
    assert_capture_blocks_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode && !cap_evt |=> gr == $past(gr));
    assert_host_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_mode && host_we |=> gr == $past(host_wdata));
endmodule

// File: rtl/ccu_flag.sv
// One sticky status flag with read-then-write-zero clearing, a
// transfer-engine clear and an interrupt request. A set event beats any
// clear request arriving in the same cycle.
module ccu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wbit,
    input  logic xfer_ack,
    input  logic xfer_noclr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic armed_q;
    logic host_clr;
    logic xfer_clr;
    logic flag_d;

    // Clear requests and next flag value, set taking priority.
    always_comb begin
        host_clr = wr_stat && !wbit && armed_q;
        xfer_clr = xfer_ack && !xfer_noclr;
        if (set_evt)                  flag_d = 1'b1;
        else if (host_clr || xfer_clr) flag_d = 1'b0;
        else                          flag_d = flag;
    end

    // Flag state and its read-of-one arming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag <= flag_d;
            if (!flag_d)              armed_q <= 1'b0;
            else if (rd_stat && flag) armed_q <= 1'b1;
        end
    end

    // Interrupt request gated by its enable.
    assign irq = flag & irq_en;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    assert_hold_without_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(wr_stat && !wbit && armed_q) && !(xfer_ack && !xfer_noclr) |=> flag);
    assert_xfer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack && !xfer_noclr && !set_evt |=> !flag);
    assert_unarmed_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !armed_q && !xfer_ack |=> flag);
endmodule

// File: rtl/ccu_chan.sv
// Capture-compare channel top: counter, host register decode, control
// word and, when HAS_REGS is set, NREG general registers with flags.
// Assumes 3*NREG <= CNT_W so the control word fits a data word.
module ccu_chan #(
    parameter int CNT_W    = 16,
    parameter int NREG     = 2,
    parameter bit HAS_REGS = 1'b1,
    parameter int SYNC_STG = 2,
    parameter int ADDR_W   = $clog2(ccu_pkg::GR_BASE + NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [CNT_W-1:0]  host_wdata,
    output logic [CNT_W-1:0]  host_rdata,
    input  logic [NREG-1:0]   cap_in,
    input  logic [NREG-1:0]   xfer_ack,
    input  logic              xfer_noclr,
    output logic [NREG-1:0]   irq
);
    import ccu_pkg::*;

    localparam int CTRL_W = 3 * NREG;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_wr;
    logic              cnt_adv;
    logic              wr_stat;
    logic              rd_stat;
    logic              wr_ctrl;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NREG-1:0]   flag_q;
    logic [CNT_W-1:0]  gr_q [NREG];

    // Address decode for the write and read strobes.
    always_comb begin
        cnt_wr  = host_wr && (int'(host_addr) == A_CNT);
        wr_ctrl = host_wr && (int'(host_addr) == A_CTRL);
        wr_stat = host_wr && (int'(host_addr) == A_STAT);
        rd_stat = host_rd && (int'(host_addr) == A_STAT);
        cnt_adv = cnt_tick && !cnt_wr;
        cnt_next = cnt_q + 1'b1;
    end

    // Free-running counter; a host write takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= host_wdata;
        else if (cnt_tick) cnt_q <= cnt_next;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick && !cnt_wr |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_count_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(host_wdata));

    generate
        if (HAS_REGS) begin : g_regs
            // Control word: mode, edge select and interrupt enable per register.
            always_ff @(posedge clk) begin
                if (!rst_n)       ctrl_q <= '0;
                else if (wr_ctrl) ctrl_q <= host_wdata[CTRL_W-1:0];
            end

            for (genvar i = 0; i < NREG; i++) begin : g_ch
                logic cap_evt;
                logic set_evt;
                logic gr_we;

                assign gr_we = host_wr && (int'(host_addr) == GR_BASE + i);

                ccu_edge_sync #(.STAGES(SYNC_STG)) u_sync (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .din      (cap_in[i]),
                    .fall_sel (ctrl_q[NREG + i]),
                    .edge_o   (cap_evt)
                );

                ccu_gr #(.W(CNT_W)) u_gr (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .cap_mode   (ctrl_q[i]),
                    .cap_evt    (cap_evt),
                    .cnt_now    (cnt_q),
                    .cnt_next   (cnt_next),
                    .cnt_adv    (cnt_adv),
                    .host_we    (gr_we),
                    .host_wdata (host_wdata),
                    .gr         (gr_q[i]),
                    .set_evt    (set_evt)
                );

                ccu_flag u_flag (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .set_evt    (set_evt),
                    .rd_stat    (rd_stat),
                    .wr_stat    (wr_stat),
                    .wbit       (host_wdata[i]),
                    .xfer_ack   (xfer_ack[i]),
                    .xfer_noclr (xfer_noclr),
                    .irq_en     (ctrl_q[2*NREG + i]),
                    .flag       (flag_q[i]),
                    .irq        (irq[i])
                );
            end
        end else begin : g_none
            assign ctrl_q = '0;
            assign flag_q = '0;
            assign irq    = '0;
            for (genvar i = 0; i < NREG; i++) begin : g_zero
                assign gr_q[i] = '0;
            end
        end
    endgenerate

    // Combinational read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (int'(host_addr) == A_CNT)       host_rdata = cnt_q;
        else if (int'(host_addr) == A_CTRL) host_rdata[CTRL_W-1:0] = ctrl_q;
        else if (int'(host_addr) == A_STAT) host_rdata[NREG-1:0] = flag_q;
        for (int i = 0; i < NREG; i++) begin
            if (int'(host_addr) == GR_BASE + i) host_rdata = gr_q[i];
        end
    end
endmodule

// File: tb/tb_ccu_chan.sv
module tb_ccu_chan;
    localparam int W = 16;
    localparam int N = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_tick = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [W-1:0]  host_wdata = '0;
    logic [W-1:0]  rdata, rdata_nr;
    logic [N-1:0]  cap_in = '0;
    logic [N-1:0]  xfer_ack = '0;
    logic          xfer_noclr = 1'b0;
    logic [N-1:0]  irq, irq_nr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ccu_chan #(.CNT_W(W), .NREG(N), .HAS_REGS(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(rdata), .cap_in(cap_in), .xfer_ack(xfer_ack),
        .xfer_noclr(xfer_noclr), .irq(irq));

    ccu_chan #(.CNT_W(W), .NREG(N), .HAS_REGS(1'b0)) dut_nr (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(rdata_nr), .cap_in(cap_in), .xfer_ack(xfer_ack),
        .xfer_noclr(xfer_noclr), .irq(irq_nr));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        @(negedge clk);
        host_addr = AW'(a); host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        @(negedge clk);
        host_addr = AW'(a); host_rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        rd(0, d); chk("R11 counter", d, 0);
        rd(1, d); chk("R11 control", d, 0);
        rd(2, d); chk("R11 flags", d, 0);
        rd(3, d); chk("R11 gr0", d, 16'hFFFF);
        chk("R11 irq", irq, 0);
    endtask

    task automatic t_count();
        logic [W-1:0] d;
        wr(0, 100); tick(5); rd(0, d); chk("R1 count", d, 105);
        @(negedge clk);
        host_addr = 0; host_wdata = 7; host_wr = 1'b1; cnt_tick = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cnt_tick = 1'b0;
        rd(0, d); chk("R1 write beats tick", d, 7);
    endtask

    task automatic t_compare_clear();
        logic [W-1:0] d;
        wr(1, 16'h0010);
        wr(3, 20); wr(0, 15);
        tick(4); chk("R2 no early match", irq[0], 0);
        tick(1); chk("R2 match sets flag", irq[0], 1);
        chk("R9 irq follows flag", irq[1], 0);
        wr(2, 0); chk("R6 unarmed zero write", irq[0], 1);
        rd(2, d); chk("R5 status read", d, 1);
        wr(2, 16'h0003); chk("R6 write one", irq[0], 1);
        wr(2, 0); chk("R5 armed clear irq", irq[0], 0);
        rd(2, d); chk("R5 armed clear flag", d, 0);
    endtask

    task automatic t_arm_persist();
        logic [W-1:0] d;
        wr(3, 30); wr(0, 29); tick(1);
        rd(2, d); chk("R2 second match", d, 1);
        wr(0, 29); tick(1);
        wr(2, 0); rd(2, d); chk("R5 arm survives set", d, 0);
    endtask

    task automatic t_set_wins();
        logic [W-1:0] d;
        wr(3, 40); wr(0, 39); tick(1);
        rd(2, d); wr(0, 39);
        @(negedge clk);
        host_addr = 2; host_wdata = 0; host_wr = 1'b1; cnt_tick = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cnt_tick = 1'b0;
        chk("R8 set wins irq", irq[0], 1);
        rd(2, d); chk("R8 set wins flag", d, 1);
        wr(2, 0); chk("R5 clear after set-wins", irq[0], 0);
    endtask

    task automatic t_xfer();
        wr(0, 39); tick(1);
        chk("R7 flag up", irq[0], 1);
        @(negedge clk); xfer_ack = 2'b01; xfer_noclr = 1'b1;
        @(negedge clk); xfer_ack = 2'b00; xfer_noclr = 1'b0;
        chk("R7 no-clear service", irq[0], 1);
        @(negedge clk); xfer_ack = 2'b01;
        @(negedge clk); xfer_ack = 2'b00;
        chk("R7 service clears", irq[0], 0);
    endtask

    task automatic t_capture();
        logic [W-1:0] d;
        wr(1, 16'h0022); wr(0, 16'h1234);
        wr(4, 16'h5555); rd(4, d); chk("R3 host write ignored", d, 16'hFFFF);
        @(negedge clk); cap_in[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 not yet after two edges", irq[1], 0);
        @(negedge clk);
        chk("R3 flag on third edge", irq[1], 1);
        rd(4, d); chk("R3 captured count", d, 16'h1234);
        rd(2, d); wr(2, 0); chk("R5 clear capture flag", irq[1], 0);
    endtask

    task automatic t_falling();
        logic [W-1:0] d;
        wr(1, 16'h002A); wr(0, 16'h0777);
        @(negedge clk); cap_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 falling edge sets", irq[1], 1);
        rd(4, d); chk("R4 falling capture", d, 16'h0777);
        rd(2, d); wr(2, 0);
        wr(0, 16'h0888);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 rising ignored", irq[1], 0);
        rd(4, d); chk("R4 register kept", d, 16'h0777);
    endtask

    task automatic t_noregs();
        @(negedge clk); host_addr = 2; #1;
        chk("R10 status reads zero", rdata_nr, 0);
        host_addr = 1; #1;
        chk("R10 control reads zero", rdata_nr, 0);
        host_addr = 3; #1;
        chk("R10 register reads zero", rdata_nr, 0);
        host_addr = 0; #1;
        chk("R10 counter present", rdata_nr, 16'h0888);
        chk("R10 irq low", irq_nr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_compare_clear();
        t_arm_persist();
        t_set_wins();
        t_xfer();
        t_capture();
        t_falling();
        t_noregs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule